// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block collects a parameterised set of level-sensitive interrupt lines (32 by default) and reduces them to two processor-facing requests: a normal interrupt request and a fast interrupt request. The raw level of every line is captured each clock. Two independent enable masks, one for each request, select which lines can raise that request. A request output is high whenever at least one enabled line is active.

Software reaches the controller through a simple word-indexed register port. The masks cannot be written directly. Each mask has one index that sets bits and a second index that clears them. Line 0 has a software latch that is ORed with the external line 0. Software can therefore raise an interrupt on its own without hiding a hardware assertion on that line.

Several controllers can be chained by wiring the request output of one instance into an input line of another. The block has no priority logic, no vector generation and no edge capture.

Top module: `dual_irq_ctrl`

## Requirements
- R1: The captured level of line n equals `src_in[n]` one clock after it is sampled. Reads at index 1 and at index 9 both return the full level word.
- R2: A write at index 2 ORs the write data into the normal-request mask. A write at index 3 clears every mask bit whose data bit is 1. A read at index 2 returns the normal-request mask.
- R3: A write at index 10 ORs the write data into the fast-request mask. A write at index 11 clears every mask bit whose data bit is 1. A read at index 10 returns the fast-request mask.
- R4: A read at index 0 returns level AND normal-request mask. A read at index 8 returns level AND fast-request mask.
- R5: A write at index 4 with data bit 0 = 1 sets the software latch of line 0. A write at index 5 with data bit 0 = 1 clears it. Writes at index 4 or 5 with data bit 0 = 0 have no effect. A read at index 4 returns level bit 0 in bit 0 and zeros in all other bits.
- R6: Level bit 0 is the OR of the captured `src_in[0]` and the software latch, so clearing the latch does not hide a hardware assertion.
- R7: `irq_o` is high one clock after (level AND normal-request mask) becomes nonzero. It is low one clock after that value becomes zero.
- R8: `fiq_o` follows (level AND fast-request mask) with the same one-clock delay.
- R9: Reads at indices 3, 5, 11 and at any unlisted index return 0. Writes at indices 0, 1, 8, 9 and at any unlisted index change no state.
- R10: While `rst_n` is low, both masks and the software latch clear to zero and both outputs are driven low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Level-sensitive interrupt lines |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_idx | input | ADDR_W | Word index of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current index (combinational) |
| irq_o | output | 1 | Normal interrupt request (registered) |
| fiq_o | output | 1 | Fast interrupt request (registered) |

## Verification
A corrupted mask bit appears on the next read of its mask index or its status index. It also shows at a request output two clocks after the matching line changes level. A software latch stuck in the wrong state shows in level bit 0 on the next read of index 1, 4 or 9. With a mask enabled, it shows at the outputs one clock later. The bench recomputes every readable word and both outputs after each operation, so a wrong internal state is caught within the operation that exposes it.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  localparam int IDX_IRQ_STAT = 0;
  localparam int IDX_RAW_A    = 1;
  localparam int IDX_IRQ_MSET = 2;
  localparam int IDX_IRQ_MCLR = 3;
  localparam int IDX_SOFT_SET = 4;
  localparam int IDX_SOFT_CLR = 5;
  localparam int IDX_FIQ_STAT = 8;
  localparam int IDX_RAW_B    = 9;
  localparam int IDX_FIQ_MSET = 10;
  localparam int IDX_FIQ_MCLR = 11;

  localparam int NCHAN  = 2;
  localparam int CH_IRQ = 0;
  localparam int CH_FIQ = 1;

  typedef struct packed {
    logic [NCHAN-1:0] mset;
    logic [NCHAN-1:0] mclr;
    logic             soft_set;
    logic             soft_clr;
  } wr_strobe_t;
endpackage

// File: rtl/dirq_decode.sv
module dirq_decode
  import dirq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_idx,
  input  logic              wdata_b0,
  output wr_strobe_t        strb
);
  always_comb begin
    strb = '0;
    if (bus_en && bus_we) begin
      case (int'(bus_idx))
        IDX_IRQ_MSET: strb.mset[CH_IRQ] = 1'b1;
        IDX_IRQ_MCLR: strb.mclr[CH_IRQ] = 1'b1;
        IDX_FIQ_MSET: strb.mset[CH_FIQ] = 1'b1;
        IDX_FIQ_MCLR: strb.mclr[CH_FIQ] = 1'b1;
        IDX_SOFT_SET: strb.soft_set     = wdata_b0;
        IDX_SOFT_CLR: strb.soft_clr     = wdata_b0;
        default:      strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/dirq_mask_reg.sv
module dirq_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] data,
  output logic [W-1:0] mask
);
  function automatic logic [W-1:0] next_mask(input logic [W-1:0] cur,
                                             input logic s, input logic c,
                                             input logic [W-1:0] d);
    logic [W-1:0] r;
    r = cur;
    if (s) r = r | d;
    if (c) r = r & ~d;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) mask <= '0;
    else        mask <= next_mask(mask, set_en, clr_en, data);
  end
endmodule

// File: rtl/dirq_source.sv
module dirq_source #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            soft_set,
  input  logic            soft_clr,
  output logic [NSRC-1:0] lvl_eff,
  output logic            soft_q
);
  logic [NSRC-1:0] lvl_q;

  function automatic logic [NSRC-1:0] merge_soft(input logic [NSRC-1:0] hw,
                                                 input logic sw);
    logic [NSRC-1:0] r;
    r    = hw;
    r[0] = hw[0] | sw;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      soft_q <= 1'b0;
    end else begin
      lvl_q <= src_in;
      if (soft_set)      soft_q <= 1'b1;
      else if (soft_clr) soft_q <= 1'b0;
    end
  end

  assign lvl_eff = merge_soft(lvl_q, soft_q);
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import dirq_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_idx,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int PADW = DATA_W - NSRC;

  wr_strobe_t      strb;
  logic [NSRC-1:0] lvl_eff;
  logic            soft_q;
  logic [NSRC-1:0] mask_q [NCHAN];
  logic [NCHAN-1:0] req_d;
  logic [NCHAN-1:0] req_q;

  // Named internal events for the checker
  logic            ev_irq_set, ev_irq_clr, ev_fiq_set, ev_fiq_clr;
  logic            ev_soft_set, ev_soft_clr;
  logic [NSRC-1:0] irq_mask, fiq_mask;
  logic [NSRC-1:0] wmask_data;

  assign wmask_data = bus_wdata[NSRC-1:0];

  dirq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_idx  (bus_idx),
    .wdata_b0 (bus_wdata[0]),
    .strb     (strb)
  );

  dirq_source #(.NSRC(NSRC)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_in   (src_in),
    .soft_set (strb.soft_set),
    .soft_clr (strb.soft_clr),
    .lvl_eff  (lvl_eff),
    .soft_q   (soft_q)
  );

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    dirq_mask_reg #(.W(NSRC)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (strb.mset[c]),
      .clr_en (strb.mclr[c]),
      .data   (wmask_data),
      .mask   (mask_q[c])
    );
    assign req_d[c] = |(lvl_eff & mask_q[c]);
    always_ff @(posedge clk) begin
      if (!rst_n) req_q[c] <= 1'b0;
      else        req_q[c] <= req_d[c];
    end
  end

  assign irq_mask    = mask_q[CH_IRQ];
  assign fiq_mask    = mask_q[CH_FIQ];
  assign ev_irq_set  = strb.mset[CH_IRQ];
  assign ev_irq_clr  = strb.mclr[CH_IRQ];
  assign ev_fiq_set  = strb.mset[CH_FIQ];
  assign ev_fiq_clr  = strb.mclr[CH_FIQ];
  assign ev_soft_set = strb.soft_set;
  assign ev_soft_clr = strb.soft_clr;
  assign irq_o       = req_q[CH_IRQ];
  assign fiq_o       = req_q[CH_FIQ];

  function automatic logic [DATA_W-1:0] widen(input logic [NSRC-1:0] v);
    return {{PADW{1'b0}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] read_word(input logic [ADDR_W-1:0] idx,
                                                  input logic [NSRC-1:0] lvl,
                                                  input logic [NSRC-1:0] im,
                                                  input logic [NSRC-1:0] fm);
    case (int'(idx))
      IDX_IRQ_STAT: return widen(lvl & im);
      IDX_RAW_A:    return widen(lvl);
      IDX_IRQ_MSET: return widen(im);
      IDX_SOFT_SET: return {{(DATA_W-1){1'b0}}, lvl[0]};
      IDX_FIQ_STAT: return widen(lvl & fm);
      IDX_RAW_B:    return widen(lvl);
      IDX_FIQ_MSET: return widen(fm);
      default:      return '0;
    endcase
  endfunction

  assign bus_rdata = read_word(bus_idx, lvl_eff, irq_mask, fiq_mask);
endmodule

// File: rtl/dual_irq_ctrl_chk.sv
module dual_irq_ctrl_chk #(
  parameter int NSRC = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_in,
  input logic [NSRC-1:0] wdata,
  input logic            ev_irq_set,
  input logic            ev_irq_clr,
  input logic            ev_fiq_set,
  input logic            ev_fiq_clr,
  input logic            ev_soft_set,
  input logic            ev_soft_clr,
  input logic [NSRC-1:0] lvl_eff,
  input logic [NSRC-1:0] irq_mask,
  input logic [NSRC-1:0] fiq_mask,
  input logic            irq_o,
  input logic            fiq_o
);
  p_irq_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_irq_set |=> ((irq_mask & $past(wdata)) == $past(wdata)));
  p_irq_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_irq_clr |=> ((irq_mask & $past(wdata)) == '0));
  p_fiq_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fiq_set |=> ((fiq_mask & $past(wdata)) == $past(wdata)));
  p_fiq_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fiq_clr |=> ((fiq_mask & $past(wdata)) == '0));
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_irq_set || ev_irq_clr) |=> $stable(irq_mask));
  p_fiq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_fiq_set || ev_fiq_clr) |=> $stable(fiq_mask));
  p_hw_bit0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    src_in[0] |=> lvl_eff[0]);
  p_soft_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_soft_set |=> lvl_eff[0]);
  p_soft_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_soft_set && ev_soft_clr));
  p_irq_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lvl_eff & irq_mask)) |=> irq_o);
  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(lvl_eff & irq_mask)) |=> !irq_o);
  p_fiq_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lvl_eff & fiq_mask)) |=> fiq_o);
  p_fiq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(lvl_eff & fiq_mask)) |=> !fiq_o);
endmodule

bind dual_irq_ctrl dual_irq_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_in      (src_in),
  .wdata       (wmask_data),
  .ev_irq_set  (ev_irq_set),
  .ev_irq_clr  (ev_irq_clr),
  .ev_fiq_set  (ev_fiq_set),
  .ev_fiq_clr  (ev_fiq_clr),
  .ev_soft_set (ev_soft_set),
  .ev_soft_clr (ev_soft_clr),
  .lvl_eff     (lvl_eff),
  .irq_mask    (irq_mask),
  .fiq_mask    (fiq_mask),
  .irq_o       (irq_o),
  .fiq_o       (fiq_o)
);

// File: tb/dual_irq_ctrl_test.sv
`timescale 1ns/1ps
module dual_irq_ctrl_test;
  localparam int NSRC = 32;
  localparam int DW   = 32;
  localparam int AW   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NSRC-1:0] src_in = '0;
  logic          bus_en = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_idx = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_o, fiq_o;

  int checks = 0;
  int fails  = 0;

  // Bench model
  logic [31:0] m_hw = '0;
  logic        m_soft = 1'b0;
  logic [31:0] m_im = '0;
  logic [31:0] m_fm = '0;

  always #4 clk = ~clk;

  dual_irq_ctrl #(.NSRC(NSRC), .DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_en(bus_en), .bus_we(bus_we),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic logic [31:0] f_level();
    return m_hw | {31'd0, m_soft};
  endfunction

  function automatic logic [31:0] f_read(input int idx);
    logic [31:0] l;
    l = f_level();
    if (idx == 0) return l & m_im;
    if (idx == 1 || idx == 9) return l;
    if (idx == 2) return m_im;
    if (idx == 4) return {31'd0, l[0]};
    if (idx == 8) return l & m_fm;
    if (idx == 10) return m_fm;
    return 32'd0;
  endfunction

  function automatic string f_tag(input int idx);
    if (idx == 0 || idx == 8) return "R4";
    if (idx == 1 || idx == 9) return "R1";
    if (idx == 2) return "R2";
    if (idx == 10) return "R3";
    if (idx == 4) return "R5";
    return "R9";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_idx = AW'(idx); bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    case (idx)
      2:  m_im = m_im | d;
      3:  m_im = m_im & ~d;
      4:  if (d[0]) m_soft = 1'b1;
      5:  if (d[0]) m_soft = 1'b0;
      10: m_fm = m_fm | d;
      11: m_fm = m_fm & ~d;
      default: ;
    endcase
  endtask

  task automatic bus_read(input int idx, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_idx = AW'(idx);
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic set_src(input logic [31:0] v);
    @(negedge clk);
    src_in = v;
    m_hw = v;
  endtask

  // Two idle negedges: level captured, then outputs registered
  task automatic check_all(input string tag);
    logic [31:0] d;
    @(negedge clk);
    @(negedge clk);
    chk({"R7 irq_o ", tag}, {31'd0, irq_o}, {31'd0, |(f_level() & m_im)});
    chk({"R8 fiq_o ", tag}, {31'd0, fiq_o}, {31'd0, |(f_level() & m_fm)});
    foreach (IDXS[i]) begin
      bus_read(IDXS[i], d);
      chk(f_tag(IDXS[i]), d, f_read(IDXS[i]));
    end
  endtask

  int IDXS[7] = '{0, 1, 2, 4, 8, 9, 10};

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1234_5678));
    repeat (4) @(negedge clk);
    // R10: reset state, checked while reset is held
    chk("R10 irq_o in reset", {31'd0, irq_o}, 32'd0);
    chk("R10 fiq_o in reset", {31'd0, fiq_o}, 32'd0);
    bus_read(2, d); chk("R10 irq mask", d, 32'd0);
    bus_read(10, d); chk("R10 fiq mask", d, 32'd0);
    rst_n = 1'b1;
    check_all("after reset");

    // R2/R3 directed set/clear
    bus_write(2, 32'h0000_00F0);
    bus_write(10, 32'h8000_0001);
    set_src(32'h8000_0010);
    check_all("masks enabled");
    bus_write(3, 32'h0000_0010);
    check_all("irq cleared bit4");
    bus_write(11, 32'h8000_0000);
    check_all("fiq cleared bit31");

    // R5/R6 soft latch with hardware line 0
    bus_write(4, 32'h0000_0000);
    check_all("R5 soft set with bit0 zero");
    bus_write(4, 32'h0000_0001);
    check_all("R5 soft set");
    set_src(32'h0000_0001);
    bus_write(5, 32'h0000_0001);
    check_all("R6 soft clear under hw");
    set_src(32'h0000_0000);
    check_all("R6 all low");

    // R9 ignored writes and zero reads
    bus_write(0, 32'hFFFF_FFFF);
    bus_write(1, 32'hFFFF_FFFF);
    bus_write(8, 32'hFFFF_FFFF);
    bus_write(9, 32'hFFFF_FFFF);
    bus_write(15, 32'hFFFF_FFFF);
    check_all("R9 status writes ignored");
    set_src(32'hFFFF_FFFF);
    bus_write(4, 32'h1);
    @(negedge clk);
    bus_read(3, d);  chk("R9 read idx3", d, 32'd0);
    bus_read(5, d);  chk("R9 read idx5", d, 32'd0);
    bus_read(11, d); chk("R9 read idx11", d, 32'd0);
    bus_read(13, d); chk("R9 read idx13", d, 32'd0);

    // Constrained random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom_range(0, 3);
      if (op == 0) begin
        logic [31:0] v;
        v = $urandom() & $urandom();
        set_src(v);
      end else begin
        int idx;
        logic [31:0] v;
        idx = (op == 1) ? $urandom_range(0, 15) : (($urandom_range(0, 1) == 0) ?
              $urandom_range(2, 5) : $urandom_range(10, 11));
        v = $urandom();
        bus_write(idx, v);
      end
      check_all("random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule